// File: doc/BRIEF.md
# Correlating Global-History Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a shift register of the resolved outcomes of the most recent branches, from any branch in the program. It joins that history with the low bits of the branch address. The combined value selects one saturating counter in a table, and the counter's top bit is the prediction. The lookup is combinational, so the prediction appears in the same cycle as the lookup address.

When a branch resolves, the pipeline returns three things: the branch address, the real outcome, and the history value that was shown at lookup time. Only the counter that made the prediction moves one step toward the outcome. The outcome is also shifted into the history register. The history length, the counter width and the number of address bits are parameters. A history length of zero turns the block into a plain address-indexed table of counters.

Top module: `gh_corr_predictor`

## Requirements
- R1: After reset, every counter holds the weakly not-taken value 2^(CTR_W-1)-1 (binary 01 for 2-bit counters). The prediction is therefore 0 for every address, and the history reads all zeros.
- R2: The prediction is combinational, in the same cycle. It is the most significant bit of the counter at index {history, lookup_pc[IDX_W-1:0]}, with the history in the upper bits. A value of 1 means taken.
- R3: On an update, the selected counter goes up by one for a taken outcome and down by one for a not-taken outcome. A counter at its maximum stays there when taken, and a counter at zero stays there when not taken.
- R4: With 2-bit counters, one not-taken outcome on a strongly-taken counter leaves the prediction taken. A second consecutive not-taken outcome flips it to not-taken.
- R5: With CTR_W-bit counters, a saturated taken counter keeps predicting taken through 2^(CTR_W-1)-1 consecutive not-taken outcomes. It flips on the 2^(CTR_W-1)-th.
- R6: Each valid update shifts the outcome into bit 0 of the history. Older bits move up one place, and the oldest bit is dropped.
- R7: An update changes only the counter at index {resolve_hist, resolve_pc[IDX_W-1:0]}. Every other counter keeps its value.
- R8: Address bits at or above IDX_W are ignored. Addresses that share their low IDX_W bits, under the same history, share one counter. There are no tags.
- R9: With HIST_W = 0, the prediction depends only on the low address bits, and updates do not change which counter a lookup uses.
- R10: When a lookup and an update hit the same counter in the same cycle, the lookup returns the value from before the update.
- R11: While resolve_valid is low, neither the counters nor the history change, whatever the other resolve inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lookup_pc | input | PC_W | Address of the branch being predicted |
| predict_taken | output | 1 | Predicted direction, 1 means taken |
| lookup_hist | output | max(HIST_W,1) | Current history, to be carried with the branch until it resolves (0 when HIST_W = 0) |
| resolve_valid | input | 1 | An update is presented this cycle |
| resolve_pc | input | PC_W | Address of the resolved branch |
| resolve_taken | input | 1 | Real outcome of the resolved branch |
| resolve_hist | input | max(HIST_W,1) | History snapshot taken when this branch was predicted |

## Verification
The bench builds three copies of the block and drives them from the same stimulus:
- A 4-bit history, 2-bit counter, 3 address-bit build. It is the main correlating case, where history steers which counter is read.
- A build with no history. It shows the plain address-indexed behaviour and gives a same-cycle lookup-versus-update case whose result can be read straight from the port.
- A 2-bit history, 3-bit counter build. It makes the four-miss flip point of wider counters observable.

Aliasing through high address bits, saturation at both ends of the counter and history ageing are all checked against literal values. A long pseudo-random run is compared against a behavioural table for all three builds.

// File: rtl/gh_corr_predictor.sv
module gh_corr_predictor #(
  parameter int PC_W   = 32,
  parameter int HIST_W = 4,
  parameter int CTR_W  = 2,
  parameter int IDX_W  = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [PC_W-1:0]                       lookup_pc,
  output logic                                  predict_taken,
  output logic [((HIST_W > 0) ? HIST_W : 1)-1:0] lookup_hist,
  input  logic                                  resolve_valid,
  input  logic [PC_W-1:0]                       resolve_pc,
  input  logic                                  resolve_taken,
  input  logic [((HIST_W > 0) ? HIST_W : 1)-1:0] resolve_hist
);
  localparam int HV    = (HIST_W > 0) ? HIST_W : 1;
  localparam int IW    = HIST_W + IDX_W;
  localparam int DEPTH = 1 << IW;
  localparam logic [CTR_W-1:0] CMAX  = {CTR_W{1'b1}};
  localparam logic [CTR_W-1:0] CINIT = CTR_W'((1 << (CTR_W - 1)) - 1);

  logic [CTR_W-1:0] pht [DEPTH];
  logic [HV-1:0]    ghr;
  logic [IW-1:0]    rd_idx, wr_idx;
  logic [CTR_W-1:0] wr_cur;
  logic             unused_hi;

  assign unused_hi = ^{lookup_pc[PC_W-1:IDX_W], resolve_pc[PC_W-1:IDX_W]};

  generate
    if (HIST_W > 0) begin : g_hist
      logic [HV-1:0] ghr_nxt;
      if (HIST_W == 1) begin : g_one
        assign ghr_nxt = resolve_taken;
      end else begin : g_many
        assign ghr_nxt = {ghr[HV-2:0], resolve_taken};
      end
      assign rd_idx = {ghr, lookup_pc[IDX_W-1:0]};
      assign wr_idx = {resolve_hist, resolve_pc[IDX_W-1:0]};

      always_ff @(posedge clk) begin
        if (!rst_n)             ghr <= '0;
        else if (resolve_valid) ghr <= ghr_nxt;
      end

      a_r6_hist_lsb: assert property (@(posedge clk) disable iff (!rst_n)
        resolve_valid |=> lookup_hist[0] == $past(resolve_taken));
      a_r11_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !resolve_valid |=> $stable(lookup_hist));
      if (HIST_W > 1) begin : g_age
        a_r6_hist_age: assert property (@(posedge clk) disable iff (!rst_n)
          resolve_valid |=> lookup_hist[HV-1:1] == $past(lookup_hist[HV-2:0]));
      end
    end else begin : g_flat
      logic unused_rhist;
      assign unused_rhist = ^resolve_hist;
      assign ghr    = '0;
      assign rd_idx = lookup_pc[IDX_W-1:0];
      assign wr_idx = resolve_pc[IDX_W-1:0];
    end
  endgenerate

  assign wr_cur        = pht[wr_idx];
  assign predict_taken = pht[rd_idx][CTR_W-1];
  assign lookup_hist   = ghr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) pht[i] <= CINIT;
    end else if (resolve_valid) begin
      if (resolve_taken && wr_cur != CMAX)       pht[wr_idx] <= wr_cur + 1'b1;
      else if (!resolve_taken && wr_cur != '0)   pht[wr_idx] <= wr_cur - 1'b1;
    end
  end

  logic             chk_v, chk_dir;
  logic [IW-1:0]    chk_idx;
  logic [CTR_W-1:0] chk_old;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_v   <= 1'b0;
      chk_dir <= 1'b0;
      chk_idx <= '0;
      chk_old <= '0;
    end else begin
      if (chk_v) begin
        a_r3_no_overflow: assert (!(chk_dir && chk_old == CMAX) || pht[chk_idx] == CMAX)
          else $error("R3 counter wrapped past maximum");
        a_r3_no_underflow: assert (!(!chk_dir && chk_old == '0) || pht[chk_idx] == '0)
          else $error("R3 counter wrapped below zero");
        a_r3_monotonic: assert (chk_dir ? (pht[chk_idx] >= chk_old) : (pht[chk_idx] <= chk_old))
          else $error("R3 counter moved against outcome");
      end
      chk_v   <= resolve_valid;
      chk_dir <= resolve_taken;
      chk_idx <= wr_idx;
      chk_old <= wr_cur;
    end
  end
endmodule

// File: tb/tb_gh_corr_predictor.sv
`timescale 1ns/1ps
module tb_gh_corr_predictor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] pc = '0, upd_pc = '0;
  logic upd_v = 1'b0, upd_t = 1'b0;
  logic [3:0] uh = '0;
  logic p4, p0, p3;
  logic [3:0] ph4;
  logic [0:0] ph0;
  logic [1:0] ph3;
  int n_cmp = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  gh_corr_predictor #(.PC_W(32), .HIST_W(4), .CTR_W(2), .IDX_W(3)) dut (
    .clk(clk), .rst_n(rst_n), .lookup_pc(pc), .predict_taken(p4), .lookup_hist(ph4),
    .resolve_valid(upd_v), .resolve_pc(upd_pc), .resolve_taken(upd_t), .resolve_hist(uh));
  gh_corr_predictor #(.PC_W(32), .HIST_W(0), .CTR_W(2), .IDX_W(3)) dut_k0 (
    .clk(clk), .rst_n(rst_n), .lookup_pc(pc), .predict_taken(p0), .lookup_hist(ph0),
    .resolve_valid(upd_v), .resolve_pc(upd_pc), .resolve_taken(upd_t), .resolve_hist(uh[0:0]));
  gh_corr_predictor #(.PC_W(32), .HIST_W(2), .CTR_W(3), .IDX_W(2)) dut_n3 (
    .clk(clk), .rst_n(rst_n), .lookup_pc(pc), .predict_taken(p3), .lookup_hist(ph3),
    .resolve_valid(upd_v), .resolve_pc(upd_pc), .resolve_taken(upd_t), .resolve_hist(uh[1:0]));

  logic [1:0] m4 [128];
  logic [1:0] m0 [8];
  logic [2:0] m3 [16];
  logic [3:0] h4;
  logic [1:0] h3;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] sat2(input logic [1:0] v, input logic t);
    if (t) return (v == 2'd3) ? v : v + 2'd1;
    return (v == 2'd0) ? v : v - 2'd1;
  endfunction
  function automatic logic [2:0] sat3(input logic [2:0] v, input logic t);
    if (t) return (v == 3'd7) ? v : v + 3'd1;
    return (v == 3'd0) ? v : v - 3'd1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 128; i++) m4[i] = 2'b01;
    for (int i = 0; i < 8; i++)   m0[i] = 2'b01;
    for (int i = 0; i < 16; i++)  m3[i] = 3'b011;
    h4 = '0; h3 = '0;
  endtask

  task automatic model_update(input logic [31:0] a, input logic t, input logic [3:0] h);
    m4[{h, a[2:0]}]      = sat2(m4[{h, a[2:0]}], t);
    m0[a[2:0]]           = sat2(m0[a[2:0]], t);
    m3[{h[1:0], a[1:0]}] = sat3(m3[{h[1:0], a[1:0]}], t);
    h4 = {h4[2:0], t};
    h3 = {h3[0], t};
  endtask

  task automatic do_upd(input logic [31:0] a, input logic t, input logic [3:0] h);
    @(negedge clk);
    upd_pc = a; upd_t = t; uh = h; upd_v = 1'b1;
    @(posedge clk);
    model_update(a, t, h);
    #1 upd_v = 1'b0;
  endtask

  task automatic expect_all(input logic [31:0] a, input string tag);
    pc = a;
    #1;
    chk({tag, " R2 k4 prediction"}, p4, m4[{h4, a[2:0]}][1]);
    chk({tag, " R9 k0 prediction"}, p0, m0[a[2:0]][1]);
    chk({tag, " R5 n3 prediction"}, p3, m3[{h3, a[1:0]}][2]);
    chk({tag, " R6 k4 history"}, ph4, h4);
    chk({tag, " R6 n3 history"}, ph3, h3);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    model_reset();
    for (int a = 0; a < 8; a++) begin
      pc = a; #1;
      chk("R1 k4 reset prediction", p4, 0);
      chk("R1 k0 reset prediction", p0, 0);
      chk("R1 n3 reset prediction", p3, 0);
    end
    chk("R1 k4 reset history", ph4, 0);
    chk("R1 n3 reset history", ph3, 0);
  endtask

  task automatic t_history();
    do_upd(32'h40, 1'b1, 4'h0);
    do_upd(32'h40, 1'b0, 4'h0);
    do_upd(32'h40, 1'b1, 4'h0);
    do_upd(32'h40, 1'b1, 4'h0);
    #1 chk("R6 history after 1,0,1,1", ph4, 4'b1011);
    chk("R6 short history after 1,0,1,1", ph3, 2'b11);
    do_upd(32'h40, 1'b0, 4'h0);
    #1 chk("R6 oldest bit dropped", ph4, 4'b0110);
    chk("R6 short history oldest dropped", ph3, 2'b10);
  endtask

  task automatic t_idle();
    @(negedge clk);
    upd_pc = 32'h5; upd_t = 1'b1; uh = 4'h6; upd_v = 1'b0;
    repeat (3) @(posedge clk);
    #1 chk("R11 history held while idle", ph4, 4'b0110);
    for (int a = 0; a < 8; a++) expect_all(a, "R11 idle sweep");
  endtask

  task automatic t_hyst();
    for (int i = 0; i < 3; i++) do_upd(32'h5, 1'b1, 4'hA);
    pc = 32'h5; #1 chk("R4 trained taken", p0, 1);
    do_upd(32'h5, 1'b0, 4'hA);
    pc = 32'h5; #1 chk("R4 one miss keeps taken", p0, 1);
    do_upd(32'h5, 1'b0, 4'hA);
    pc = 32'h5; #1 chk("R4 second miss flips", p0, 0);
  endtask

  task automatic t_flat();
    for (int i = 0; i < 2; i++) do_upd(32'h5, 1'b1, 4'h3);
    pc = 32'h5; #1 chk("R9 k0 pc5 taken", p0, 1);
    for (int i = 0; i < 4; i++) begin
      do_upd(32'h6, i[0], 4'(i));
      pc = 32'h5; #1 chk("R9 k0 unaffected by history", p0, 1);
    end
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 5; i++) do_upd(32'h2, 1'b0, 4'h1);
    do_upd(32'h2, 1'b1, 4'h1);
    pc = 32'h2; #1 chk("R3 no underflow then one taken", p0, 0);
    do_upd(32'h2, 1'b1, 4'h1);
    pc = 32'h2; #1 chk("R3 second taken", p0, 1);
    for (int i = 0; i < 5; i++) do_upd(32'h2, 1'b1, 4'h1);
    do_upd(32'h2, 1'b0, 4'h1);
    pc = 32'h2; #1 chk("R3 no overflow then one miss", p0, 1);
    do_upd(32'h2, 1'b0, 4'h1);
    pc = 32'h2; #1 chk("R3 second miss", p0, 0);
  endtask

  task automatic t_wide();
    for (int i = 0; i < 4; i++) do_upd(32'h1, 1'b1, 4'h3);
    pc = 32'h1; #1 chk("R5 saturated taken", p3, 1);
    for (int k = 1; k <= 4; k++) begin
      do_upd(32'h1, 1'b0, 4'h3);
      do_upd(32'h2, 1'b1, 4'h0);
      do_upd(32'h2, 1'b1, 4'h0);
      pc = 32'h1; #1;
      chk("R5 short history restored", ph3, 2'b11);
      chk("R5 flip after four misses", p3, (k < 4) ? 1 : 0);
    end
  endtask

  task automatic t_alias();
    do_upd(32'h1003, 1'b1, 4'h9);
    do_upd(32'h1003, 1'b1, 4'h9);
    pc = 32'h3; #1 chk("R8 high bits ignored k0", p0, 1);
    pc = 32'hB; #1 chk("R8 alias pc 0xB k0", p0, 1);
    pc = 32'h3; #1;
    begin
      int lo = p4;
      pc = 32'h1000B; #1 chk("R8 alias same counter k4", p4, lo);
    end
  endtask

  task automatic t_bypass();
    @(negedge clk);
    pc = 32'h7; upd_pc = 32'h7; upd_t = 1'b1; uh = h4; upd_v = 1'b1;
    #1;
    chk("R10 k0 pre-update value", p0, 0);
    chk("R10 k4 pre-update value", p4, m4[{h4, 3'd7}][1]);
    @(posedge clk);
    model_update(32'h7, 1'b1, uh);
    #1 upd_v = 1'b0;
    #1 chk("R10 k0 post-update value", p0, 1);
  endtask

  task automatic t_stress();
    logic [15:0] lf = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      do_upd({20'h0, lf[11:0]}, lf[3] ^ lf[9], lf[0] ? ph4 : lf[7:4]);
      expect_all({16'h0, lf}, "R7 stress");
    end
    for (int a = 0; a < 8; a++) expect_all(a, "R7 final sweep");
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_history();
    t_idle();
    t_hyst();
    t_flat();
    t_saturate();
    t_wide();
    t_alias();
    t_bypass();
    t_stress();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule